// File: doc/BRIEF.md
# Reed-Solomon symbol error applier

This block sits after a Reed-Solomon decoder that works on 12-bit symbols. The decoder hands it a list of up to four error entries. Each entry is a symbol position and a 12-bit error pattern. The block applies every entry, in list order, to a page image held in an external byte-wide RAM. That RAM holds a 2048-byte data region followed by a spare region. The combined byte address is the data byte index for the data region, and 2048 plus the spare byte index for the spare region.

Twelve-bit symbols do not line up with bytes. Most corrections therefore touch two bytes, each through a read-modify-write XOR.
- Symbol 0 is truncated to eight bits.
- Symbol 1365 straddles the last data byte and the first spare byte.

Positions past the last valid symbol, and a symbol-0 pattern that is wider than eight bits, make the page uncorrectable. When this happens the block stops at that entry and raises a fail flag. The entries it applied before the bad one stay applied. It reports the number of symbols it corrected, then gives a one-cycle completion pulse.

Top module: `rs_symfix`

## Requirements
- R1: After reset, busy, done and fail are 0, fix_count is 0, and no RAM read or write is issued while the block is idle.
- R2: A start pulse in idle captures err_num, err_pos and err_pat. A start pulse while busy is ignored, and changes on the list inputs during a run do not affect that run.
- R3: For an odd position p below 1365, pattern bits 11:4 are XORed into byte floor(3p/2). Pattern bits 3:0, shifted into bits 7:4, are XORed into byte floor(3p/2)+1.
- R4: For an even nonzero position p below 1365, pattern bits 11:8 are XORed into bits 3:0 of byte 3p/2-1. Pattern bits 7:0 are XORed into byte 3p/2.
- R5: Position 0 touches only data byte 0, which receives pattern bits 7:0. If any of pattern bits 11:8 is set, the entry is invalid.
- R6: Position 1365 XORs pattern bits 11:4 into data byte 2047 (address 2047). It XORs pattern bits 3:0, shifted into bits 7:4, into spare byte 0 (address 2048).
- R7: Positions 1366 to 1374 use the odd/even split of R3/R4. The spare byte index is the R3/R4 byte index minus 2048, at RAM address 2048 plus that index. For example, position 1374 with pattern 0xABC XORs 0x0A into address 2060 and 0xBC into address 2061.
- R8: A position above 1374 is invalid. An invalid entry ends the run with fail set, and the entry leaves the RAM untouched.
- R9: Each affected byte costs one RAM read followed, in the next cycle, by a write of the read data XOR the mask to the same address. Entries are applied one after another, so two entries that hit the same byte both take effect.
- R10: done is a one-cycle pulse at the end of every run. fix_count then equals the number of entries applied, and fix_count and fail hold until the next accepted start. After a failure, the earlier entries remain applied and the later entries are not applied.
- R11: A list of zero entries completes with fix_count 0, fail 0 and no RAM access. A list length above 4 completes with fail 1, fix_count 0 and no RAM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin applying the presented list |
| err_num | input | 3 | Number of valid entries in the list |
| err_pos | input | 44 | Four 11-bit symbol positions, entry i at bits 11i+10:11i |
| err_pat | input | 48 | Four 12-bit error patterns, entry i at bits 12i+11:12i |
| mem_addr | output | 12 | RAM byte address |
| mem_rd | output | 1 | RAM read strobe, data returned the following cycle |
| mem_wr | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid one cycle after mem_rd |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Last run hit an uncorrectable entry |
| fix_count | output | 3 | Entries applied in the last run |

## Verification
The hardest case to reach from the ports is two neighbouring symbols sharing a byte. In that case the second read must return the first entry's write, which only works if the writes are strictly ordered. The bench reaches it with lists of adjacent odd/even positions and of a repeated position. It also sweeps every position from 0 past the valid range one entry at a time on a RAM that keeps accumulating changes. A reference builds each symbol's bit placement from a big-endian bit-stream offset of 12p-4, which is independent of the odd/even formulas.

// File: rtl/rsfx_pkg.sv
package rsfx_pkg;
  localparam int SYM_BITS  = 12;
  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHK, ST_RD0, ST_WR0, ST_RD1, ST_WR1, ST_DONE
  } fix_state_t;

  // floor(3p/2)
  function automatic logic [15:0] sym_half(input logic [15:0] p);
    return p + (p >> 1);
  endfunction

  function automatic logic [15:0] sym_first_byte(input logic [15:0] p);
    if (p == 16'd0) return 16'd0;
    if (p[0]) return sym_half(p);
    return sym_half(p) - 16'd1;
  endfunction

  function automatic logic [15:0] sym_second_byte(input logic [15:0] p);
    if (p[0]) return sym_half(p) + 16'd1;
    return sym_half(p);
  endfunction

  function automatic logic [7:0] sym_first_mask(input logic [15:0] p,
                                                input logic [SYM_BITS-1:0] pat);
    if (p == 16'd0) return pat[7:0];
    if (p[0]) return pat[11:4];
    return {4'h0, pat[11:8]};
  endfunction

  function automatic logic [7:0] sym_second_mask(input logic [15:0] p,
                                                 input logic [SYM_BITS-1:0] pat);
    if (p[0]) return {pat[3:0], 4'h0};
    return pat[7:0];
  endfunction
endpackage

// File: rtl/rsfx_map.sv
module rsfx_map
  import rsfx_pkg::*;
#(
  parameter int POS_W    = 11,
  parameter int ADDR_W   = 12,
  parameter int LAST_POS = 1374
) (
  input  logic [POS_W-1:0]    pos,
  input  logic [SYM_BITS-1:0] pat,
  output logic [ADDR_W-1:0]   addr0,
  output logic [ADDR_W-1:0]   addr1,
  output logic [7:0]          mask0,
  output logic [7:0]          mask1,
  output logic                two_bytes,
  output logic                entry_ok
);
  logic [15:0] p16;
  logic        in_range;
  logic        narrow_bad;

  assign p16        = 16'(pos);
  assign addr0      = ADDR_W'(sym_first_byte(p16));
  assign addr1      = ADDR_W'(sym_second_byte(p16));
  assign mask0      = sym_first_mask(p16, pat);
  assign mask1      = sym_second_mask(p16, pat);
  assign two_bytes  = (p16 != 16'd0);
  assign in_range   = (p16 <= 16'(LAST_POS));
  assign narrow_bad = (p16 == 16'd0) && (pat[11:8] != 4'h0);
  assign entry_ok   = in_range && !narrow_bad;
endmodule

// File: rtl/rsfx_list.sv
module rsfx_list
  import rsfx_pkg::*;
#(
  parameter int POS_W   = 11,
  parameter int MAX_ERR = 4,
  parameter int CNT_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [MAX_ERR*POS_W-1:0]    err_pos,
  input  logic [MAX_ERR*SYM_BITS-1:0] err_pat,
  input  logic [CNT_W-1:0]            idx,
  output logic [POS_W-1:0]            sel_pos,
  output logic [SYM_BITS-1:0]         sel_pat
);
  logic [POS_W-1:0]    pos_q [MAX_ERR];
  logic [SYM_BITS-1:0] pat_q [MAX_ERR];

  for (genvar g = 0; g < MAX_ERR; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos_q[g] <= '0;
        pat_q[g] <= '0;
      end else if (load) begin
        pos_q[g] <= err_pos[g*POS_W +: POS_W];
        pat_q[g] <= err_pat[g*SYM_BITS +: SYM_BITS];
      end
    end
  end

  always_comb begin
    sel_pos = '0;
    sel_pat = '0;
    for (int i = 0; i < MAX_ERR; i++) begin
      if (idx == CNT_W'(i)) begin
        sel_pos = pos_q[i];
        sel_pat = pat_q[i];
      end
    end
  end
endmodule

// File: rtl/rsfx_ctrl.sv
module rsfx_ctrl
  import rsfx_pkg::*;
#(
  parameter int MAX_ERR = 4,
  parameter int CNT_W   = 3,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  err_num,
  input  logic              entry_ok,
  input  logic              two_bytes,
  input  logic [ADDR_W-1:0] addr0,
  input  logic [ADDR_W-1:0] addr1,
  input  logic [7:0]        mask0,
  input  logic [7:0]        mask1,
  input  logic [7:0]        mem_rdata,
  output logic              load,
  output logic [CNT_W-1:0]  idx,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  fix_count
);
  fix_state_t       state;
  logic [CNT_W-1:0] num_q;
  logic             second;
  logic             entry_end;

  assign load      = (state == ST_IDLE) && start;
  assign second    = (state == ST_RD1) || (state == ST_WR1);
  assign mem_rd    = (state == ST_RD0) || (state == ST_RD1);
  assign mem_wr    = (state == ST_WR0) || (state == ST_WR1);
  assign mem_addr  = second ? addr1 : addr0;
  assign mem_wdata = mem_rdata ^ (second ? mask1 : mask0);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign entry_end = (state == ST_WR1) || ((state == ST_WR0) && !two_bytes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      num_q     <= '0;
      idx       <= '0;
      fail      <= 1'b0;
      fix_count <= '0;
    end else begin
      if (entry_end) begin
        idx       <= idx + 1'b1;
        fix_count <= fix_count + 1'b1;
      end
      case (state)
        ST_IDLE: if (start) begin
          num_q     <= err_num;
          idx       <= '0;
          fix_count <= '0;
          if (err_num > CNT_W'(MAX_ERR)) begin
            fail  <= 1'b1;
            state <= ST_DONE;
          end else begin
            fail  <= 1'b0;
            state <= ST_CHK;
          end
        end
        ST_CHK: begin
          if (idx == num_q) begin
            state <= ST_DONE;
          end else if (!entry_ok) begin
            fail  <= 1'b1;
            state <= ST_DONE;
          end else begin
            state <= ST_RD0;
          end
        end
        ST_RD0:  state <= ST_WR0;
        ST_WR0:  state <= two_bytes ? ST_RD1 : ST_CHK;
        ST_RD1:  state <= ST_WR1;
        ST_WR1:  state <= ST_CHK;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rs_symfix.sv
module rs_symfix
  import rsfx_pkg::*;
#(
  parameter int POS_W       = 11,
  parameter int MAX_ERR     = 4,
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int LAST_POS    = 1374,
  localparam int CNT_W      = $clog2(MAX_ERR + 1),
  localparam int ADDR_W     = $clog2(DATA_BYTES + SPARE_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [CNT_W-1:0]            err_num,
  input  logic [MAX_ERR*POS_W-1:0]    err_pos,
  input  logic [MAX_ERR*SYM_BITS-1:0] err_pat,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic                        mem_rd,
  output logic                        mem_wr,
  output logic [7:0]                  mem_wdata,
  input  logic [7:0]                  mem_rdata,
  output logic                        busy,
  output logic                        done,
  output logic                        fail,
  output logic [CNT_W-1:0]            fix_count
);
  logic                load;
  logic [CNT_W-1:0]    idx;
  logic [POS_W-1:0]    sel_pos;
  logic [SYM_BITS-1:0] sel_pat;
  logic [ADDR_W-1:0]   addr0, addr1;
  logic [7:0]          mask0, mask1;
  logic                two_bytes;
  logic                entry_ok;

  rsfx_list #(.POS_W(POS_W), .MAX_ERR(MAX_ERR), .CNT_W(CNT_W)) u_list (
    .clk(clk), .rst_n(rst_n), .load(load), .err_pos(err_pos), .err_pat(err_pat),
    .idx(idx), .sel_pos(sel_pos), .sel_pat(sel_pat)
  );

  rsfx_map #(.POS_W(POS_W), .ADDR_W(ADDR_W), .LAST_POS(LAST_POS)) u_map (
    .pos(sel_pos), .pat(sel_pat), .addr0(addr0), .addr1(addr1),
    .mask0(mask0), .mask1(mask1), .two_bytes(two_bytes), .entry_ok(entry_ok)
  );

  rsfx_ctrl #(.MAX_ERR(MAX_ERR), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .err_num(err_num),
    .entry_ok(entry_ok), .two_bytes(two_bytes), .addr0(addr0), .addr1(addr1),
    .mask0(mask0), .mask1(mask1), .mem_rdata(mem_rdata), .load(load), .idx(idx),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .fail(fail), .fix_count(fix_count)
  );
endmodule

// File: rtl/rsfx_chk.sv
module rsfx_chk #(
  parameter int ADDR_W    = 12,
  parameter int CNT_W     = 3,
  parameter int MAX_ERR   = 4,
  parameter int MEM_BYTES = 2112
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CNT_W-1:0]  fix_count
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));

  p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_wr_after_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd) && (mem_addr == $past(mem_addr))));

  p_addr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (int'(mem_addr) < MEM_BYTES));

  p_fail_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_count_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fix_count) <= MAX_ERR);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(fix_count) && $stable(fail)));
endmodule

bind rs_symfix rsfx_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_ERR(MAX_ERR),
  .MEM_BYTES(DATA_BYTES + SPARE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fail(fail), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
  .fix_count(fix_count)
);

// File: tb/sim_rs_symfix.sv
module sim_rs_symfix;
  localparam int CLK_PERIOD = 10;
  localparam int MEMB = 2112;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] err_num = '0;
  logic [43:0] err_pos = '0;
  logic [47:0] err_pat = '0;
  logic [11:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic busy, done, fail;
  logic [2:0] fix_count;

  logic [7:0] ram [MEMB];
  logic [7:0] refm [MEMB];
  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0;
  int tp [4];
  int tq [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_symfix u0 (.clk(clk), .rst_n(rst_n), .start(start), .err_num(err_num),
    .err_pos(err_pos), .err_pat(err_pat), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .fail(fail), .fix_count(fix_count));

  always @(posedge clk) begin
    if (mem_wr) ram[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= ram[mem_addr];
    if (rst_n && mem_rd) rd_cnt <= rd_cnt + 1;
    if (rst_n && mem_wr) wr_cnt <= wr_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mem_init();
    for (int k = 0; k < MEMB; k++) begin
      ram[k] = 8'(k * 7 + 3);
      refm[k] = 8'(k * 7 + 3);
    end
  endtask

  // symbol p sits at big-endian stream bit 12p-4; bits before 0 do not exist
  task automatic ref_apply(input int p, input int pat);
    for (int i = 0; i < 12; i++) begin
      int s;
      s = 12 * p - 4 + i;
      if (s >= 0 && ((pat >> (11 - i)) & 1) == 1)
        refm[s / 8][7 - (s % 8)] = ~refm[s / 8][7 - (s % 8)];
    end
  endtask

  task automatic mem_cmp(input string tag);
    int bad;
    bad = -1;
    for (int k = MEMB - 1; k >= 0; k--) if (ram[k] !== refm[k]) bad = k;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, {tag, " ram byte"}, int'(ram[bad]), int'(refm[bad]));
  endtask

  task automatic drive_list(input int n);
    err_num = 3'(n);
    for (int i = 0; i < 4; i++) begin
      err_pos[i*11 +: 11] = 11'(tp[i]);
      err_pat[i*12 +: 12] = 12'(tq[i]);
    end
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (done !== 1'b1 && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(done === 1'b1, "R10 done within bound", int'(done), 1);
  endtask

  task automatic run(input int n);
    @(negedge clk);
    drive_list(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  initial begin : watchdog
    repeat (WDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int r0, w0, pat;
    string tag;
    mem_init();
    for (int i = 0; i < 4; i++) begin tp[i] = 0; tq[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && fix_count == 0, "R1 reset outputs", int'({busy, done, fail}), 0);
    chk(!mem_rd && !mem_wr, "R1 no access in reset", int'({mem_rd, mem_wr}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_rd && !mem_wr && fix_count == 0, "R1 idle after reset", int'(busy), 0);

    // exhaustive single-entry sweep, accumulating on the same RAM
    for (int p = 0; p <= 1380; p++) begin
      pat = (p == 0) ? 'h5A : ((p * 37 + 5) & 'hFFF);
      if (p == 0) tag = "R5";
      else if (p < 1365) tag = (p % 2 == 1) ? "R3" : "R4";
      else if (p == 1365) tag = "R6";
      else if (p <= 1374) tag = "R7";
      else tag = "R8";
      tp[0] = p; tq[0] = pat;
      r0 = rd_cnt; w0 = wr_cnt;
      run(1);
      if (p <= 1374) begin
        ref_apply(p, pat);
        chk(!fail && fix_count == 1, {tag, " single entry result"}, int'(fix_count), 1);
        chk(rd_cnt - r0 == ((p == 0) ? 1 : 2) && wr_cnt - w0 == rd_cnt - r0,
            "R9 accesses per entry", rd_cnt - r0, (p == 0) ? 1 : 2);
      end else begin
        chk(fail && fix_count == 0, "R8 out of range fails", int'(fail), 1);
        chk(rd_cnt == r0 && wr_cnt == w0, "R8 no access", rd_cnt - r0, 0);
      end
      mem_cmp({tag, " sweep p"});
    end

    // explicit straddle and spare examples
    mem_init();
    tp[0] = 1365; tq[0] = 'hABC; tp[1] = 1374; tq[1] = 'hABC;
    run(2);
    chk(ram[2047] == (8'(2047*7+3) ^ 8'hAB), "R6 data byte 2047", int'(ram[2047]), int'(8'(2047*7+3) ^ 8'hAB));
    chk(ram[2048] == (8'(2048*7+3) ^ 8'hC0), "R6 spare byte 0", int'(ram[2048]), int'(8'(2048*7+3) ^ 8'hC0));
    chk(ram[2060] == (8'(2060*7+3) ^ 8'h0A), "R7 spare 12", int'(ram[2060]), int'(8'(2060*7+3) ^ 8'h0A));
    chk(ram[2061] == (8'(2061*7+3) ^ 8'hBC), "R7 spare 13", int'(ram[2061]), int'(8'(2061*7+3) ^ 8'hBC));
    chk(fix_count == 2 && !fail, "R10 count two", int'(fix_count), 2);

    // adjacent symbols share byte 8; repeated position cancels
    mem_init();
    tp[0] = 5; tq[0] = 'hFFF; tp[1] = 6; tq[1] = 'hFFF;
    tp[2] = 100; tq[2] = 'h3C5; tp[3] = 100; tq[3] = 'h3C5;
    run(4);
    chk(ram[8] == (8'(8*7+3) ^ 8'hFF), "R9 shared byte accumulates", int'(ram[8]), int'(8'(8*7+3) ^ 8'hFF));
    ref_apply(5, 'hFFF); ref_apply(6, 'hFFF);
    mem_cmp("R9 shared and cancel");
    chk(fix_count == 4 && !fail, "R10 count four", int'(fix_count), 4);

    // failure in the middle of a list
    mem_init();
    tp[0] = 10; tq[0] = 'h123; tp[1] = 11; tq[1] = 'h456;
    tp[2] = 1400; tq[2] = 'h777; tp[3] = 12; tq[3] = 'h888;
    run(4);
    chk(fail && fix_count == 2, "R10 partial count on fail", int'(fix_count), 2);
    ref_apply(10, 'h123); ref_apply(11, 'h456);
    mem_cmp("R10 earlier applied later not");
    repeat (3) @(negedge clk);
    chk(fail && fix_count == 2 && !done, "R10 results hold", int'(fix_count), 2);

    // wide pattern at position 0
    mem_init();
    tp[0] = 0; tq[0] = 'h100;
    r0 = rd_cnt;
    run(1);
    chk(fail && fix_count == 0 && rd_cnt == r0, "R5 wide pattern fails", int'(fail), 1);
    mem_cmp("R5 ram untouched");

    // empty and oversize lists
    r0 = rd_cnt; w0 = wr_cnt;
    run(0);
    chk(!fail && fix_count == 0 && rd_cnt == r0 && wr_cnt == w0, "R11 empty list", int'(fix_count), 0);
    tp[0] = 3; tq[0] = 'h111;
    run(5);
    chk(fail && fix_count == 0 && rd_cnt == r0 && wr_cnt == w0, "R11 oversize list", int'(fail), 1);
    mem_cmp("R11 ram untouched");

    // start while busy and list change during run
    mem_init();
    @(negedge clk);
    tp[0] = 20; tq[0] = 'h9A5;
    drive_list(1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tp[0] = 30; tq[0] = 'hFFF;
    drive_list(1);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r0 = rd_cnt;
    wait_done();
    ref_apply(20, 'h9A5);
    repeat (3) @(negedge clk);
    chk(!busy && fix_count == 1, "R2 second start ignored", int'(busy), 0);
    mem_cmp("R2 only captured list applied");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule